// File: doc/BRIEF.md
# Saturating Hit Multiplicity Merger

This block merges the hit multiplicities reported by eight cluster-processing units into one count per hit threshold. There are sixteen thresholds. Each unit supplies a 2-bit multiplicity (0 to 3) for every threshold. For each threshold the block adds the eight contributions. It then clamps the total into a 3-bit field that stops at 7 and does not wrap.

The sixteen clamped counts are split between two output words. Thresholds 0 to 7 go to the left word and thresholds 8 to 15 go to the right word, so each half can go to its own destination. Each word holds 24 count bits and one parity bit, which makes the whole 25-bit word carry an odd number of ones.

The block runs on the bunch-crossing clock with a fixed latency of two cycles. An input valid strobe marks the cycles that carry data. Cycles without the strobe change nothing at the outputs.

Top module: `hit_mult_merger`

## Requirements
- R1: While synchronous reset is high and after its release, until the first result emerges, `out_valid` is 0 and each output word has all 24 count bits zero and bit 24 set to 1.
- R2: For threshold t, the count equals the sum over sources s of the 2-bit value at `src_hits[(s*16+t)*2 +: 2]`, whenever that sum is 7 or less.
- R3: When the sum for a threshold is 7 or more (up to 24), the count is 7. A sum of exactly 6 gives 6.
- R4: Threshold t < 8 sits in `left_word[3t+2:3t]`. Threshold t >= 8 sits in `right_word[3(t-8)+2:3(t-8)]`.
- R5: Bit 24 of each output word is chosen so that the 25-bit word always has an odd number of ones.
- R6: `out_valid` is high in exactly the cycles that come two clock edges after a cycle in which `in_valid` was sampled high. The words carrying that result appear in the same cycle.
- R7: Cycles sampled with `in_valid` low leave both words unchanged, whatever `src_hits` carries, and lead to `out_valid` low two edges later.
- R8: Valid inputs on consecutive cycles each produce their own result on consecutive cycles, without loss or mixing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks cycles whose `src_hits` are to be merged |
| src_hits | input | 256 | 2-bit multiplicity for source s and threshold t at bit (s*16+t)*2 |
| out_valid | output | 1 | A new result is present on both words |
| left_word | output | 25 | Counts of thresholds 0-7, bit 24 odd parity |
| right_word | output | 25 | Counts of thresholds 8-15, bit 24 odd parity |

## Verification
The only internal state is the registered sums and their valid bit. Any corruption there reaches the ports exactly one edge later. A stale or mis-gated sum register shows up as a count that differs from the behavioural model, or as a word that moves during an idle cycle. A broken valid bit shifts `out_valid` away from the two-cycle position. The output is compared with the model on every clock, so each such fault is reported in the first cycle it becomes visible.

// File: rtl/hm_pkg.sv
package hm_pkg;
    localparam int unsigned N_SRC   = 8;
    localparam int unsigned N_THR   = 16;
    localparam int unsigned IN_W    = 2;
    localparam int unsigned CNT_W   = 3;
    localparam int unsigned HALF    = N_THR / 2;
    localparam int unsigned IN_MAX  = (1 << IN_W) - 1;
    localparam int unsigned SUM_W   = $clog2(N_SRC * IN_MAX + 1);
    localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;
    localparam int unsigned PAY_W   = HALF * CNT_W;
    localparam int unsigned WORD_W  = PAY_W + 1;
    localparam int unsigned IN_BITS = N_SRC * N_THR * IN_W;

    typedef logic [SUM_W-1:0] raw_sum_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic                       vld;
        raw_sum_t [N_THR-1:0]       sum;
    } sum_stage_t;

    function automatic logic [WORD_W-1:0] idle_word();
        return {1'b1, {PAY_W{1'b0}}};
    endfunction
endpackage

// File: rtl/hm_thr_adder.sv
module hm_thr_adder #(
    parameter int unsigned N_SRC = 8,
    parameter int unsigned IN_W  = 2,
    parameter int unsigned SUM_W = 5
) (
    input  logic [N_SRC-1:0][IN_W-1:0] vals,
    output logic [SUM_W-1:0]           sum
);
    always_comb begin
        sum = '0;
        for (int i = 0; i < int'(N_SRC); i++) begin
            sum = sum + SUM_W'(vals[i]);
        end
    end
endmodule

// File: rtl/hm_sat.sv
module hm_sat #(
    parameter int unsigned SUM_W = 5,
    parameter int unsigned CNT_W = 3
) (
    input  logic [SUM_W-1:0] raw,
    output logic [CNT_W-1:0] cnt
);
    localparam int unsigned LIMIT = (1 << CNT_W) - 1;

    generate
        if (SUM_W > CNT_W) begin : g_clip
            assign cnt = (raw > SUM_W'(LIMIT)) ? CNT_W'(LIMIT) : raw[CNT_W-1:0];
        end else begin : g_pass
            assign cnt = CNT_W'(raw);
        end
    endgenerate
endmodule

// File: rtl/hm_sum_stage.sv
module hm_sum_stage
    import hm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [IN_BITS-1:0] src_hits,
    output sum_stage_t         stg
);
    raw_sum_t [N_THR-1:0] sum_c;

    generate
        for (genvar t = 0; t < int'(N_THR); t++) begin : g_thr
            logic [N_SRC-1:0][IN_W-1:0] col;
            for (genvar s = 0; s < int'(N_SRC); s++) begin : g_src
                assign col[s] = src_hits[(s*N_THR + t)*IN_W +: IN_W];
            end
            hm_thr_adder #(
                .N_SRC (N_SRC),
                .IN_W  (IN_W),
                .SUM_W (SUM_W)
            ) u_add (
                .vals (col),
                .sum  (sum_c[t])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg.vld <= in_valid;
            if (in_valid) begin
                stg.sum <= sum_c;
            end
        end
    end
endmodule

// File: rtl/hm_half_out.sv
module hm_half_out
    import hm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld,
    input  raw_sum_t [HALF-1:0]  sums,
    output logic [WORD_W-1:0]    word
);
    cnt_t [HALF-1:0]    cnts;
    logic [PAY_W-1:0]   payload;
    logic               par;

    generate
        for (genvar k = 0; k < int'(HALF); k++) begin : g_cnt
            hm_sat #(
                .SUM_W (SUM_W),
                .CNT_W (CNT_W)
            ) u_sat (
                .raw (sums[k]),
                .cnt (cnts[k])
            );

            AST_SAT_FIELD: assert property (@(posedge clk) disable iff (rst)
                (ld && (sums[k] >= SUM_W'(CNT_MAX))) |=> (word[k*CNT_W +: CNT_W] == CNT_W'(CNT_MAX))) // R3
                else $error("saturated field %0d not at maximum", k);
        end
    endgenerate

    assign payload = cnts;
    assign par     = ~^payload;

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= idle_word();
        end else if (ld) begin
            word <= {par, payload};
        end
    end

    AST_ODD_WORD: assert property (@(posedge clk) disable iff (rst)
        ($countones(word) % 2) == 1) // R5
        else $error("output word has even parity");

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(word)) // R7
        else $error("word changed without a load");
endmodule

// File: rtl/hit_mult_merger.sv
module hit_mult_merger
    import hm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [IN_BITS-1:0]   src_hits,
    output logic                 out_valid,
    output logic [WORD_W-1:0]    left_word,
    output logic [WORD_W-1:0]    right_word
);
    sum_stage_t              stg;
    logic [1:0][WORD_W-1:0]  words;
    logic [1:0]              age;

    hm_sum_stage u_sum (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .src_hits (src_hits),
        .stg      (stg)
    );

    generate
        for (genvar h = 0; h < 2; h++) begin : g_half
            hm_half_out u_half (
                .clk  (clk),
                .rst  (rst),
                .ld   (stg.vld),
                .sums (stg.sum[h*HALF +: HALF]),
                .word (words[h])
            );
        end
    endgenerate

    assign left_word  = words[0];
    assign right_word = words[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= stg.vld;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    AST_LAT_TWO: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (out_valid == $past(in_valid, 2))) // R6
        else $error("out_valid not two cycles after in_valid");

    AST_EARLY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (age < 2'd2) |-> !out_valid) // R1
        else $error("out_valid high before a result can exist");
endmodule

// File: tb/sim_hit_mult_merger.sv
`timescale 1ns/1ps
module sim_hit_mult_merger;
    import hm_pkg::*;

    logic                clk = 1'b0;
    logic                rst;
    logic                in_valid;
    logic [IN_BITS-1:0]  src_hits;
    logic                out_valid;
    logic [WORD_W-1:0]   left_word;
    logic [WORD_W-1:0]   right_word;

    always #2.5 clk = ~clk;

    hit_mult_merger u0 (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .src_hits   (src_hits),
        .out_valid  (out_valid),
        .left_word  (left_word),
        .right_word (right_word)
    );

    typedef struct {
        logic              v;
        logic [WORD_W-1:0] l;
        logic [WORD_W-1:0] r;
    } exp_t;

    exp_t  q[$];
    exp_t  mdl;
    int    n_run  = 0;
    int    n_fail = 0;
    string tag    = "R1";
    bit    done   = 0;

    function automatic exp_t model(logic v, logic [IN_BITS-1:0] h);
        exp_t e;
        e.v = v;
        e.l = '0;
        e.r = '0;
        for (int t = 0; t < int'(N_THR); t++) begin
            int acc = 0;
            for (int s = 0; s < int'(N_SRC); s++) begin
                acc += int'(h[(s*N_THR + t)*IN_W +: IN_W]);
            end
            if (acc > 7) acc = 7;
            if (t < 8) e.l[3*t +: 3] = 3'(acc);
            else       e.r[3*(t-8) +: 3] = 3'(acc);
        end
        e.l[24] = ~^e.l[23:0];
        e.r[24] = ~^e.r[23:0];
        return e;
    endfunction

    task automatic chk(string req, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        q.delete();
        mdl.v = 1'b0;
        mdl.l = {1'b1, 24'b0};
        mdl.r = {1'b1, 24'b0};
    endtask

    // one clock: compare outputs with the model, then apply new stimulus
    task automatic step(logic v, logic [IN_BITS-1:0] h);
        exp_t e;
        @(negedge clk);
        if (q.size() >= 2) begin
            e = q.pop_front();
            mdl.v = e.v;
            if (e.v) begin
                mdl.l = e.l;
                mdl.r = e.r;
            end
        end
        chk({"R6 out_valid / ", tag}, WORD_W'(out_valid), WORD_W'(mdl.v));
        chk({tag, " left"}, left_word, mdl.l);
        chk({tag, " right"}, right_word, mdl.r);
        chk("R5 left parity", WORD_W'($countones(left_word) % 2), WORD_W'(1));
        chk("R5 right parity", WORD_W'($countones(right_word) % 2), WORD_W'(1));
        in_valid = v;
        src_hits = h;
        q.push_back(model(v, h));
    endtask

    function automatic logic [IN_BITS-1:0] put(logic [IN_BITS-1:0] h, int s, int t, int val);
        h[(s*N_THR + t)*IN_W +: IN_W] = IN_W'(val);
        return h;
    endfunction

    function automatic logic [IN_BITS-1:0] rnd_hits();
        logic [IN_BITS-1:0] h;
        for (int i = 0; i < int'(IN_BITS/32); i++) h[i*32 +: 32] = $urandom;
        return h;
    endfunction

    function automatic logic [IN_BITS-1:0] sparse_hits();
        logic [IN_BITS-1:0] h = '0;
        for (int t = 0; t < int'(N_THR); t++)
            for (int s = 0; s < int'(N_SRC); s++)
                if ($urandom_range(3, 0) == 0) h = put(h, s, t, int'($urandom_range(3, 0)));
        return h;
    endfunction

    initial begin
        logic [IN_BITS-1:0] h;
        rst      = 1'b1;
        in_valid = 1'b0;
        src_hits = '0;
        model_reset();
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", WORD_W'(out_valid), '0);
        chk("R1 left", left_word, 25'h1000000);
        chk("R1 right", right_word, 25'h1000000);
        rst = 1'b0;
        model_reset();

        // R4 / R2: field positions
        tag = "R4";
        h = put('0, 5, 3, 2);
        h = put(h, 0, 12, 3);
        h = put(h, 7, 12, 1);
        step(1'b1, h);
        step(1'b0, '0);
        step(1'b0, '0);
        chk("R4 left field 3", WORD_W'(left_word[11:9]), WORD_W'(2));
        chk("R4 right field 4", WORD_W'(right_word[14:12]), WORD_W'(4));

        // R3: boundaries 6, 7, 8 and all at maximum
        tag = "R3";
        h = put('0, 0, 0, 2); h = put(h, 1, 0, 2); h = put(h, 2, 0, 2);     // 6
        h = put(h, 0, 9, 3);  h = put(h, 1, 9, 3); h = put(h, 2, 9, 1);     // 7
        h = put(h, 0, 15, 3); h = put(h, 1, 15, 3); h = put(h, 2, 15, 2);   // 8
        step(1'b1, h);
        step(1'b1, '1);
        step(1'b0, '0);
        chk("R3 sum six", WORD_W'(left_word[2:0]), WORD_W'(6));
        chk("R3 sum seven", WORD_W'(right_word[5:3]), WORD_W'(7));
        chk("R3 sum eight", WORD_W'(right_word[23:21]), WORD_W'(7));
        step(1'b0, '0);
        chk("R3 all max left", left_word, 25'h1FFFFFF);
        chk("R3 all max right", right_word, 25'h1FFFFFF);

        // R7: idle cycles with noise on the inputs
        tag = "R7";
        for (int i = 0; i < 50; i++) step(1'b0, rnd_hits());

        // R8: back-to-back valid results
        tag = "R8";
        for (int i = 0; i < 300; i++) step(1'b1, sparse_hits());

        // R2: mixed valid and idle, sparse and dense
        tag = "R2";
        for (int i = 0; i < 2000; i++) begin
            step($urandom_range(2, 0) != 0, (i % 3 == 0) ? rnd_hits() : sparse_hits());
        end
        for (int i = 0; i < 3; i++) step(1'b0, '0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule